// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block unlocks a door after a user keys in a secret code of three 4-bit digits, one at a time and in order. Each digit arrives on a 4-bit value bus, and a one-cycle strobe marks it as valid. A small datapath stores the code digits and uses a one-hot multiplexer to pick the digit that is expected next. An equality comparator checks the entered value against that digit. A separate controller steps through the entry states and decides whether the door opens.

The state register uses a 4-bit encoding chosen so that the outputs need no decoding. The three entry states are 0001, 0010 and 0100. The open state is 1000. The error state is all zeros. The multiplexer select is the low three state bits, and the open output is the top state bit. One wrong digit sends the lock to the error state. The lock stays in the error state, or in the open state, until a synchronous restart returns it to the first entry state. The code digits reset to 3, 4, 2. Each digit can be rewritten through a load port, but only while the lock waits for its first digit.

Top module: `seq_code_lock`

## Requirements
- R1: After the asynchronous reset is released, door_open is 0 and mux_sel is 001, which means the lock waits for the first digit.
- R2: In an entry state, a strobed value equal to the selected digit advances the lock one step: mux_sel goes 001 to 010 to 100. After the third correct digit, mux_sel is 000 and door_open is 1. Each output change is seen after the clock edge that samples the strobe.
- R3: In any state, a cycle with no strobe and no restart leaves door_open and mux_sel unchanged.
- R4: In an entry state, a strobed value that differs from the selected digit sends the lock to the error state (mux_sel 000, door_open 0). A wrong digit in the first, middle or last position all do this.
- R5: The error state and the open state ignore strobed values of any kind and hold until restart.
- R6: Restart returns the lock to the first entry state (mux_sel 001, door_open 0) from any state. Restart takes priority over a strobe in the same cycle.
- R7: After the asynchronous reset, the stored code is 3, 4, 2, with digit index 0 entered first.
- R8: A load (load_en high, load_idx 0 to 2 picking the digit, load_val the new value) writes that digit only while mux_sel is 001. A load in any other state is ignored.
- R9: door_open is 1 only in the open state, and at most one bit of {door_open, mux_sel} is set in any cycle. An unused state encoding falls to the error state.
- R10: Every cycle in which the strobe is high counts as one entry. A strobe held high for two cycles with the same value is two entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| restart | input | 1 | Synchronous return to the first entry state |
| key_strobe | input | 1 | Marks key_val as a new entry for this cycle |
| key_val | input | 4 | Entered digit |
| load_en | input | 1 | Write enable for one code digit |
| load_idx | input | 2 | Code digit to write (0 is entered first) |
| load_val | input | 4 | New code digit value |
| door_open | output | 1 | 1 when the door is open |
| mux_sel | output | 3 | One-hot select of the expected digit; 000 in open and error states |

## Verification
The checker checks several rules on every cycle. The outputs are never more than one-hot. An idle cycle leaves the state unchanged. Open and error hold until restart. Restart always lands in the first entry state. A strobed digit either shifts the one-hot state up by one position or clears it, depending on the comparison with the selected digit.

Some behaviour is visible only in the bench's scenarios. These are the actual code values after reset and after a load, a load being ignored outside the first entry state, and a held strobe counting twice. The bench also runs wrong digits in each position and restart from both the open and error states.

// File: rtl/lock_pkg.sv
package lock_pkg;
  // Default geometry of the lock.
  localparam int DEF_DIGIT_W    = 4;
  localparam int DEF_NUM_DIGITS = 3;
  // Default code; digit 0 sits in the least significant field and is entered first.
  localparam logic [DEF_NUM_DIGITS*DEF_DIGIT_W-1:0] DEF_CODE = {4'd2, 4'd4, 4'd3};

  // Width of an index able to address n digits (never below one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lock_rst_sync.sv
module lock_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  // Assert at once, release after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/lock_code_store.sv
module lock_code_store
  import lock_pkg::*;
#(
  parameter int DIGIT_W    = DEF_DIGIT_W,
  parameter int NUM_DIGITS = DEF_NUM_DIGITS,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] RESET_CODE = DEF_CODE,
  localparam int IDX_W     = idx_width(NUM_DIGITS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_allow,
  input  logic                          load_en,
  input  logic [IDX_W-1:0]              load_idx,
  input  logic [DIGIT_W-1:0]            load_val,
  output logic [NUM_DIGITS*DIGIT_W-1:0] code_flat
);
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    logic               wr_en;
    logic [DIGIT_W-1:0] digit_q;

    // Clock enable: the digit is addressed and the controller allows writes.
    assign wr_en = load_en && wr_allow && (load_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        digit_q <= RESET_CODE[g*DIGIT_W +: DIGIT_W];
      end else if (wr_en) begin
        digit_q <= load_val;
      end
    end

    assign code_flat[g*DIGIT_W +: DIGIT_W] = digit_q;
  end
endmodule

// File: rtl/lock_digit_select.sv
module lock_digit_select
  import lock_pkg::*;
#(
  parameter int DIGIT_W    = DEF_DIGIT_W,
  parameter int NUM_DIGITS = DEF_NUM_DIGITS
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] code_flat,
  input  logic [NUM_DIGITS-1:0]         sel,
  input  logic [DIGIT_W-1:0]            key_val,
  output logic [DIGIT_W-1:0]            sel_digit,
  output logic                          digit_match
);
  logic [DIGIT_W-1:0] masked [NUM_DIGITS];

  // One-hot AND-OR multiplexer: each leg gated by its select bit.
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_leg
    assign masked[g] = code_flat[g*DIGIT_W +: DIGIT_W] & {DIGIT_W{sel[g]}};
  end

  always_comb begin
    sel_digit = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      sel_digit = sel_digit | masked[i];
    end
  end

  // Equality comparator; no match is reported when nothing is selected.
  assign digit_match = (|sel) && (key_val == sel_digit);
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
#(
  parameter int NUM_DIGITS = DEF_NUM_DIGITS,
  localparam int ST_W      = NUM_DIGITS + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  key_strobe,
  input  logic                  digit_match,
  output logic [NUM_DIGITS-1:0] mux_sel,
  output logic                  door_open,
  output logic                  at_first
);
  localparam logic [ST_W-1:0] ST_ERR   = '0;
  localparam logic [ST_W-1:0] ST_FIRST = ST_W'(1);
  localparam logic [ST_W-1:0] ST_OPEN  = ST_W'(1) << NUM_DIGITS;

  logic [ST_W-1:0] st_q;
  logic [ST_W-1:0] st_d;
  logic            st_en;
  logic            in_entry;
  int              low_ones;

  // An entry state has exactly one of the low bits set and the top bit clear.
  always_comb begin
    low_ones = 0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      low_ones = low_ones + int'(st_q[i]);
    end
    in_entry = (low_ones == 1) && !st_q[ST_W-1];
  end

  // Next-state logic.
  always_comb begin
    if (restart) begin
      st_d = ST_FIRST;
    end else if (in_entry) begin
      if (key_strobe) begin
        st_d = digit_match ? (st_q << 1) : ST_ERR;
      end else begin
        st_d = st_q;
      end
    end else if ((st_q == ST_OPEN) || (st_q == ST_ERR)) begin
      st_d = st_q;
    end else begin
      st_d = ST_ERR;  // any unused encoding is treated as an error
    end
  end

  assign st_en = (st_d != st_q);

  // State register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_FIRST;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign mux_sel   = st_q[NUM_DIGITS-1:0];
  assign door_open = st_q[ST_W-1];
  assign at_first  = (st_q == ST_FIRST);
endmodule

// File: rtl/seq_code_lock.sv
module seq_code_lock
  import lock_pkg::*;
#(
  parameter int DIGIT_W    = DEF_DIGIT_W,
  parameter int NUM_DIGITS = DEF_NUM_DIGITS,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] RESET_CODE = DEF_CODE,
  localparam int IDX_W     = idx_width(NUM_DIGITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  key_strobe,
  input  logic [DIGIT_W-1:0]    key_val,
  input  logic                  load_en,
  input  logic [IDX_W-1:0]      load_idx,
  input  logic [DIGIT_W-1:0]    load_val,
  output logic                  door_open,
  output logic [NUM_DIGITS-1:0] mux_sel
);
  logic                          rst_sync_n;
  logic [NUM_DIGITS*DIGIT_W-1:0] code_flat;
  logic [DIGIT_W-1:0]            sel_digit;
  logic                          digit_match;
  logic                          at_first;

  lock_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lock_code_store #(
    .DIGIT_W    (DIGIT_W),
    .NUM_DIGITS (NUM_DIGITS),
    .RESET_CODE (RESET_CODE)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_allow  (at_first),
    .load_en   (load_en),
    .load_idx  (load_idx),
    .load_val  (load_val),
    .code_flat (code_flat)
  );

  lock_digit_select #(
    .DIGIT_W    (DIGIT_W),
    .NUM_DIGITS (NUM_DIGITS)
  ) u_select (
    .code_flat   (code_flat),
    .sel         (mux_sel),
    .key_val     (key_val),
    .sel_digit   (sel_digit),
    .digit_match (digit_match)
  );

  lock_ctrl #(
    .NUM_DIGITS (NUM_DIGITS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .restart     (restart),
    .key_strobe  (key_strobe),
    .digit_match (digit_match),
    .mux_sel     (mux_sel),
    .door_open   (door_open),
    .at_first    (at_first)
  );
endmodule

// File: rtl/lock_checker.sv
module lock_checker #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  restart,
  input logic                  key_strobe,
  input logic [DIGIT_W-1:0]    key_val,
  input logic [DIGIT_W-1:0]    exp_digit,
  input logic                  door_open,
  input logic [NUM_DIGITS-1:0] mux_sel
);
  logic in_entry;
  assign in_entry = (|mux_sel) && !door_open;

  p_one_hot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({door_open, mux_sel}));

  p_restart_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (mux_sel == NUM_DIGITS'(1)) && !door_open);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !key_strobe) |=> $stable({door_open, mux_sel}));

  p_open_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (door_open && !restart) |=> door_open);

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!door_open && (mux_sel == '0) && !restart) |=> (!door_open && (mux_sel == '0)));

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_strobe && !restart && in_entry && (key_val == exp_digit))
      |=> ({door_open, mux_sel} == {$past(mux_sel), 1'b0}));

  p_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_strobe && !restart && in_entry && (key_val != exp_digit))
      |=> (!door_open && (mux_sel == '0)));
endmodule

bind seq_code_lock lock_checker #(
  .DIGIT_W    (DIGIT_W),
  .NUM_DIGITS (NUM_DIGITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .restart    (restart),
  .key_strobe (key_strobe),
  .key_val    (key_val),
  .exp_digit  (sel_digit),
  .door_open  (door_open),
  .mux_sel    (mux_sel)
);

// File: tb/seq_code_lock_bench.sv
`timescale 1ns/1ps
module seq_code_lock_bench;
  logic       clk;
  logic       rst_n;
  logic       restart;
  logic       key_strobe;
  logic [3:0] key_val;
  logic       load_en;
  logic [1:0] load_idx;
  logic [3:0] load_val;
  logic       door_open;
  logic [2:0] mux_sel;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  seq_code_lock u_seq_code_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .key_strobe (key_strobe),
    .key_val    (key_val),
    .load_en    (load_en),
    .load_idx   (load_idx),
    .load_val   (load_val),
    .door_open  (door_open),
    .mux_sel    (mux_sel)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector fields: {restart, strobe, value[3:0], exp_open, exp_sel[2:0]}.
  // Encodings: sel 001/010/100 wait for digit 0/1/2, 000 is open or error.
  localparam int NV = 17;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd0, 1'b0, 3'b001},  // idle in first state (R3)
    {1'b0, 1'b1, 4'd3, 1'b0, 3'b010},  // correct digit 0 (R2, R7)
    {1'b0, 1'b0, 4'd3, 1'b0, 3'b010},  // idle gap (R3)
    {1'b0, 1'b1, 4'd4, 1'b0, 3'b100},  // correct digit 1
    {1'b0, 1'b1, 4'd2, 1'b1, 3'b000},  // correct digit 2 -> open
    {1'b0, 1'b1, 4'd7, 1'b1, 3'b000},  // strobe ignored in open (R5)
    {1'b1, 1'b0, 4'd0, 1'b0, 3'b001},  // restart from open (R6)
    {1'b0, 1'b1, 4'd5, 1'b0, 3'b000},  // wrong first digit (R4)
    {1'b0, 1'b1, 4'd3, 1'b0, 3'b000},  // error holds (R5)
    {1'b1, 1'b0, 4'd0, 1'b0, 3'b001},  // restart from error (R6)
    {1'b0, 1'b1, 4'd3, 1'b0, 3'b010},
    {1'b0, 1'b1, 4'd4, 1'b0, 3'b100},
    {1'b0, 1'b1, 4'd9, 1'b0, 3'b000},  // wrong last digit (R4)
    {1'b1, 1'b1, 4'd3, 1'b0, 3'b001},  // restart beats strobe (R6)
    {1'b0, 1'b1, 4'd3, 1'b0, 3'b010},
    {1'b0, 1'b1, 4'd2, 1'b0, 3'b000},  // wrong middle digit (R4)
    {1'b1, 1'b0, 4'd0, 1'b0, 3'b001}
  };

  task automatic check(input string req, input logic got_open, input logic [2:0] got_sel,
                       input logic exp_open, input logic [2:0] exp_sel);
    n_checks++;
    if (got_open !== exp_open || got_sel !== exp_sel) begin
      n_fails++;
      $display("FAIL %s: got open=%b sel=%b, expected open=%b sel=%b",
               req, got_open, got_sel, exp_open, exp_sel);
    end
  endtask

  // Called at a falling edge; drives one cycle and returns at the next falling edge.
  task automatic step(input logic rs, input logic st, input logic [3:0] v);
    restart    = rs;
    key_strobe = st;
    key_val    = v;
    @(negedge clk);
    restart    = 1'b0;
    key_strobe = 1'b0;
  endtask

  task automatic load(input logic [1:0] idx, input logic [3:0] v);
    load_en  = 1'b1;
    load_idx = idx;
    load_val = v;
    @(negedge clk);
    load_en  = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; restart = 1'b0; key_strobe = 1'b0; key_val = '0;
    load_en = 1'b0; load_idx = '0; load_val = '0;
    do_reset();
    check("R1 reset state", door_open, mux_sel, 1'b0, 3'b001);

    // Table walk: R2/R3/R4/R5/R6.
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9], VEC[i][8], VEC[i][7:4]);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), door_open, mux_sel,
            VEC[i][3], VEC[i][2:0]);
    end

    // R8: load digit 1 = 9 while in first state, then 3,9,2 opens.
    load(2'd1, 4'd9);
    check("R8 load keeps first state", door_open, mux_sel, 1'b0, 3'b001);
    step(1'b0, 1'b1, 4'd3);
    step(1'b0, 1'b1, 4'd9);
    step(1'b0, 1'b1, 4'd2);
    check("R8 loaded digit accepted", door_open, mux_sel, 1'b1, 3'b000);

    // R8: load outside first state is ignored.
    step(1'b1, 1'b0, 4'd0);
    step(1'b0, 1'b1, 4'd3);
    load(2'd2, 4'd5);
    step(1'b0, 1'b1, 4'd9);
    check("R8 mid-entry", door_open, mux_sel, 1'b0, 3'b100);
    step(1'b0, 1'b1, 4'd2);
    check("R8 load outside first state ignored", door_open, mux_sel, 1'b1, 3'b000);

    // R10: held strobe counts twice; second entry 3 mismatches digit 1 (9).
    step(1'b1, 1'b0, 4'd0);
    restart = 1'b0; key_strobe = 1'b1; key_val = 4'd3;
    @(negedge clk);
    check("R10 first cycle of held strobe", door_open, mux_sel, 1'b0, 3'b010);
    @(negedge clk);
    key_strobe = 1'b0;
    check("R10 second cycle counts as entry", door_open, mux_sel, 1'b0, 3'b000);

    // R7: asynchronous reset restores code 3,4,2.
    do_reset();
    check("R1 reset from error", door_open, mux_sel, 1'b0, 3'b001);
    step(1'b0, 1'b1, 4'd3);
    step(1'b0, 1'b1, 4'd4);
    step(1'b0, 1'b1, 4'd2);
    check("R7 default code after reset", door_open, mux_sel, 1'b1, 3'b000);

    // R9: open output only in open state, idle there holds.
    step(1'b0, 1'b0, 4'd0);
    check("R9 open state exclusive", door_open, mux_sel, 1'b1, 3'b000);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got no completion, expected completion within 5000 cycles");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule